// File: doc/BRIEF.md
# Address-Space-Tagged Translation Lookaside Buffer

This block is a small, fully associative cache of recent virtual-page to physical-page translations. It sits in front of a page table walker. A lookup presents an address-space identifier and a virtual address. In the same cycle the block answers in one of two ways. On a hit, it returns the physical address and the cached permission flags. On a miss, it signals the miss, and the walker then resolves the translation and hands it back through the fill port.

Context switches can be handled in two ways. Software may flush the whole buffer. Software may instead rely on the address-space identifier that every entry carries, since a lookup only hits when that identifier matches. A targeted flush removes the entries of one identifier and leaves all the others in place.

Each clock the block performs one write operation, decoded from the command inputs:
- OP_IDLE: no command.
- OP_FILL: install a translation.
- OP_FLUSH_ALL: invalidate every entry.
- OP_FLUSH_ASID: invalidate the entries of one identifier.

A flush takes precedence over a fill in the same cycle. After each edge the decode returns to OP_IDLE unless a command is still held.

Top module: `tlb_xlate_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: With lk_valid high, lk_hit is high in the same cycle exactly when a valid entry holds the same identifier and the same page number (lk_vaddr[38:12]). Otherwise lk_miss is high. With lk_valid low, both outputs are low.
- R3: On a hit, lk_paddr is the cached 44-bit page number followed by lk_vaddr[11:0], and lk_perm gives the cached flags in the order {user, execute, write, read} from bit 3 down to bit 0. On a miss, both lk_paddr and lk_perm are zero.
- R4: A fill is written at the next rising edge. A lookup in the same cycle as the fill does not see it; a lookup in the following cycle does.
- R5: The identifier is part of the match. The same page number under a different identifier misses. Two entries with the same page number and different identifiers coexist, and each returns its own translation.
- R6: flush_en with flush_by_asid low invalidates every entry at the next edge.
- R7: flush_en with flush_by_asid high invalidates only the entries whose identifier equals flush_asid. All other entries keep hitting.
- R8: A fill presented in the same cycle as any flush is discarded.
- R9: A fill whose identifier and page number match a valid entry overwrites that entry with the new page number and flags. It uses no further slot.
- R10: A fill that matches no entry takes the lowest-numbered invalid entry. When all 8 entries are valid, it replaces the entry at a round-robin pointer. The pointer is 0 after reset and advances by one only when such a replacement happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_asid | input | 16 | Lookup address-space identifier |
| lk_vaddr | input | 39 | Lookup virtual address |
| lk_hit | output | 1 | Lookup found a translation |
| lk_miss | output | 1 | Lookup found no translation |
| lk_paddr | output | 56 | Translated physical address |
| lk_perm | output | 4 | Cached flags {U,X,W,R} |
| fill_en | input | 1 | Install a translation |
| fill_asid | input | 16 | Identifier of the fill |
| fill_vpn | input | 27 | Virtual page number of the fill |
| fill_ppn | input | 44 | Physical page number of the fill |
| fill_perm | input | 4 | Flags of the fill {U,X,W,R} |
| flush_en | input | 1 | Flush command |
| flush_by_asid | input | 1 | 1: flush one identifier, 0: flush all |
| flush_asid | input | 16 | Identifier to flush |

## Verification
Lookups are made with matching and non-matching page numbers under one identifier, and with the same page number under two identifiers. These separate a correct tag compare from one that ignores either field. Fill sequences are applied in three patterns: repeated fills of one key, eight distinct keys into an empty buffer, and a ninth and tenth key into a full buffer. Between them they separate overwriting from duplicating, and invalid-first placement from round-robin eviction. Flushes are issued globally, per identifier, and in the same cycle as a fill, which separates the three invalidation paths and the command precedence.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_FILL,
        OP_FLUSH_ALL,
        OP_FLUSH_ASID
    } tlb_op_e;

    typedef struct packed {
        logic u;
        logic x;
        logic w;
        logic r;
    } tlb_perm_t;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int N      = 8,
    parameter int ASID_W = 16,
    parameter int VPN_W  = 27,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]             valid_vec,
    input  logic [N-1:0][ASID_W-1:0] tag_asid,
    input  logic [N-1:0][VPN_W-1:0]  tag_vpn,
    input  logic [ASID_W-1:0]        req_asid,
    input  logic [VPN_W-1:0]         req_vpn,
    output logic [N-1:0]             hit_vec,
    output logic                     any_hit,
    output logic [IDX_W-1:0]         hit_idx
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid_vec[g]
                          && (tag_asid[g] == req_asid)
                          && (tag_vpn[g] == req_vpn);
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N      = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid_vec,
    input  logic             fill_go,
    input  logic             fill_hit,
    input  logic [IDX_W-1:0] fill_hit_idx,
    output logic [IDX_W-1:0] victim_idx
);

    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] free_idx;
    logic             has_free;

    always_comb begin
        free_idx = '0;
        has_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_idx = IDX_W'(i);
                has_free = 1'b1;
            end
        end
    end

    always_comb begin
        if (fill_hit)      victim_idx = fill_hit_idx;
        else if (has_free) victim_idx = free_idx;
        else               victim_idx = rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (fill_go && !fill_hit && !has_free) begin
            if (rr_ptr == IDX_W'(N - 1)) rr_ptr <= '0;
            else                         rr_ptr <= rr_ptr + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_xlate_cache.sv
module tlb_xlate_cache
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int ASID_W  = 16,
    parameter int VPN_W   = 27,
    parameter int PPN_W   = 44,
    parameter int OFF_W   = 12,
    localparam int VA_W   = VPN_W + OFF_W,
    localparam int PA_W   = PPN_W + OFF_W,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VA_W-1:0]   lk_vaddr,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic [PA_W-1:0]   lk_paddr,
    output logic [3:0]        lk_perm,
    input  logic              fill_en,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [3:0]        fill_perm,
    input  logic              flush_en,
    input  logic              flush_by_asid,
    input  logic [ASID_W-1:0] flush_asid
);

    logic [ENTRIES-1:0]             ent_valid;
    logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
    logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
    logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;
    tlb_perm_t [ENTRIES-1:0]        ent_perm;

    tlb_op_e op;

    logic [ENTRIES-1:0] lk_hit_vec;
    logic               lk_any;
    logic [IDX_W-1:0]   lk_idx;
    logic [ENTRIES-1:0] fl_hit_vec;
    logic               fl_any;
    logic [IDX_W-1:0]   fl_idx;
    logic [IDX_W-1:0]   victim_idx;
    logic [ENTRIES-1:0] asid_kill;

    // Command decode: a flush outranks a fill.
    always_comb begin
        if (flush_en)     op = flush_by_asid ? OP_FLUSH_ASID : OP_FLUSH_ALL;
        else if (fill_en) op = OP_FILL;
        else              op = OP_IDLE;
    end

    tlb_match #(.N(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_lk_match (
        .valid_vec (ent_valid),
        .tag_asid  (ent_asid),
        .tag_vpn   (ent_vpn),
        .req_asid  (lk_asid),
        .req_vpn   (lk_vaddr[VA_W-1:OFF_W]),
        .hit_vec   (lk_hit_vec),
        .any_hit   (lk_any),
        .hit_idx   (lk_idx)
    );

    tlb_match #(.N(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_fl_match (
        .valid_vec (ent_valid),
        .tag_asid  (ent_asid),
        .tag_vpn   (ent_vpn),
        .req_asid  (fill_asid),
        .req_vpn   (fill_vpn),
        .hit_vec   (fl_hit_vec),
        .any_hit   (fl_any),
        .hit_idx   (fl_idx)
    );

    tlb_victim #(.N(ENTRIES)) u_victim (
        .clk          (clk),
        .rst_n        (rst_n),
        .valid_vec    (ent_valid),
        .fill_go      (op == OP_FILL),
        .fill_hit     (fl_any),
        .fill_hit_idx (fl_idx),
        .victim_idx   (victim_idx)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_kill
        assign asid_kill[g] = (ent_asid[g] == flush_asid);
    end

    // Valid-bit state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
        end else begin
            unique case (op)
                OP_IDLE:       ent_valid <= ent_valid;
                OP_FILL:       ent_valid[victim_idx] <= 1'b1;
                OP_FLUSH_ALL:  ent_valid <= '0;
                OP_FLUSH_ASID: ent_valid <= ent_valid & ~asid_kill;
                default:       ent_valid <= ent_valid;
            endcase
        end
    end

    // Payload storage, no reset needed: guarded by the valid bits.
    always_ff @(posedge clk) begin
        if (op == OP_FILL) begin
            ent_asid[victim_idx] <= fill_asid;
            ent_vpn[victim_idx]  <= fill_vpn;
            ent_ppn[victim_idx]  <= fill_ppn;
            ent_perm[victim_idx] <= tlb_perm_t'(fill_perm);
        end
    end

    // Lookup outputs.
    always_comb begin
        lk_hit   = lk_valid && lk_any;
        lk_miss  = lk_valid && !lk_any;
        lk_paddr = '0;
        lk_perm  = '0;
        if (lk_hit) begin
            lk_paddr = {ent_ppn[lk_idx], lk_vaddr[OFF_W-1:0]};
            lk_perm  = ent_perm[lk_idx];
        end
    end

endmodule

// File: rtl/tlb_xlate_cache_chk.sv
module tlb_xlate_cache_chk #(
    parameter int ASID_W = 16,
    parameter int VPN_W  = 27,
    parameter int PPN_W  = 44,
    parameter int OFF_W  = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    lk_valid,
    input logic [ASID_W-1:0]       lk_asid,
    input logic [VPN_W+OFF_W-1:0]  lk_vaddr,
    input logic                    lk_hit,
    input logic                    lk_miss,
    input logic [PPN_W+OFF_W-1:0]  lk_paddr,
    input logic [3:0]              lk_perm,
    input logic                    fill_en,
    input logic [ASID_W-1:0]       fill_asid,
    input logic [VPN_W-1:0]        fill_vpn,
    input logic [PPN_W-1:0]        fill_ppn,
    input logic                    flush_en,
    input logic                    flush_by_asid,
    input logic [ASID_W-1:0]       flush_asid
);

    a_r2_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |-> (lk_hit != lk_miss));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> (!lk_hit && !lk_miss));

    a_r3_offset_passes: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    a_r3_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_paddr == '0 && lk_perm == '0));

    a_r4_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_en) ##1
        (lk_valid && lk_asid == $past(fill_asid)
                  && lk_vaddr[VPN_W+OFF_W-1:OFF_W] == $past(fill_vpn))
        |-> (lk_hit && lk_paddr[PPN_W+OFF_W-1:OFF_W] == $past(fill_ppn)));

    a_r6_flush_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && !flush_by_asid) |=> !lk_hit);

    a_r7_flush_asid_gone: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && flush_by_asid) |=> !(lk_hit && lk_asid == $past(flush_asid)));

endmodule

bind tlb_xlate_cache tlb_xlate_cache_chk #(
    .ASID_W (ASID_W),
    .VPN_W  (VPN_W),
    .PPN_W  (PPN_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_asid       (lk_asid),
    .lk_vaddr      (lk_vaddr),
    .lk_hit        (lk_hit),
    .lk_miss       (lk_miss),
    .lk_paddr      (lk_paddr),
    .lk_perm       (lk_perm),
    .fill_en       (fill_en),
    .fill_asid     (fill_asid),
    .fill_vpn      (fill_vpn),
    .fill_ppn      (fill_ppn),
    .flush_en      (flush_en),
    .flush_by_asid (flush_by_asid),
    .flush_asid    (flush_asid)
);

// File: tb/sim_tlb_xlate_cache.sv
module sim_tlb_xlate_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [15:0] lk_asid = '0;
    logic [38:0] lk_vaddr = '0;
    logic        lk_hit;
    logic        lk_miss;
    logic [55:0] lk_paddr;
    logic [3:0]  lk_perm;
    logic        fill_en = 1'b0;
    logic [15:0] fill_asid = '0;
    logic [26:0] fill_vpn = '0;
    logic [43:0] fill_ppn = '0;
    logic [3:0]  fill_perm = '0;
    logic        flush_en = 1'b0;
    logic        flush_by_asid = 1'b0;
    logic [15:0] flush_asid = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tlb_xlate_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_asid(lk_asid), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
        .fill_en(fill_en), .fill_asid(fill_asid), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_perm(fill_perm),
        .flush_en(flush_en), .flush_by_asid(flush_by_asid), .flush_asid(flush_asid)
    );

    task automatic expect_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic fill(input logic [15:0] a, input logic [26:0] v,
                        input logic [43:0] p, input logic [3:0] pm);
        @(negedge clk);
        fill_en = 1'b1; fill_asid = a; fill_vpn = v; fill_ppn = p; fill_perm = pm;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic flush(input bit by_asid, input logic [15:0] a);
        @(negedge clk);
        flush_en = 1'b1; flush_by_asid = by_asid; flush_asid = a;
        @(negedge clk);
        flush_en = 1'b0;
    endtask

    // Drives a lookup and compares the combinational answer.
    task automatic probe(string req, input logic [15:0] a, input logic [26:0] v,
                         input logic [11:0] off, input bit exp_hit,
                         input logic [43:0] exp_ppn, input logic [3:0] exp_perm);
        @(negedge clk);
        lk_valid = 1'b1; lk_asid = a; lk_vaddr = {v, off};
        #1;
        expect_eq(req, "hit", 64'(lk_hit), 64'(exp_hit));
        expect_eq(req, "miss", 64'(lk_miss), 64'(!exp_hit));
        expect_eq(req, "paddr", 64'(lk_paddr), exp_hit ? 64'({exp_ppn, off}) : 64'd0);
        expect_eq(req, "perm", 64'(lk_perm), exp_hit ? 64'(exp_perm) : 64'd0);
        lk_valid = 1'b0;
    endtask

    task automatic t_reset;
        probe("R1", 16'h1, 27'h3, 12'h2D0, 1'b0, '0, '0);
        @(negedge clk);
        lk_valid = 1'b0; lk_asid = 16'h1; lk_vaddr = '0;
        #1;
        expect_eq("R2", "idle hit", 64'(lk_hit), 64'd0);
        expect_eq("R2", "idle miss", 64'(lk_miss), 64'd0);
    endtask

    task automatic t_fill_timing;
        @(negedge clk);
        fill_en = 1'b1; fill_asid = 16'h1; fill_vpn = 27'h3; fill_ppn = 44'h7; fill_perm = 4'b0011;
        lk_valid = 1'b1; lk_asid = 16'h1; lk_vaddr = {27'h3, 12'h2D0};
        #1;
        expect_eq("R4", "same-cycle hit", 64'(lk_hit), 64'd0);
        @(negedge clk);
        fill_en = 1'b0;
        #1;
        expect_eq("R4", "next-cycle hit", 64'(lk_hit), 64'd1);
        lk_valid = 1'b0;
        probe("R3", 16'h1, 27'h3, 12'h2D0, 1'b1, 44'h7, 4'b0011);
        probe("R2", 16'h1, 27'h4, 12'h000, 1'b0, '0, '0);
    endtask

    task automatic t_asid;
        probe("R5", 16'h2, 27'h3, 12'h884, 1'b0, '0, '0);
        fill(16'h2, 27'h3, 44'h9, 4'b1100);
        probe("R5", 16'h2, 27'h3, 12'h884, 1'b1, 44'h9, 4'b1100);
        probe("R5", 16'h1, 27'h3, 12'hFA0, 1'b1, 44'h7, 4'b0011);
    endtask

    task automatic t_overwrite;
        flush(1'b0, '0);
        fill(16'hA, 27'h10, 44'h1, 4'b0001);
        fill(16'hA, 27'h10, 44'h2, 4'b0111);
        probe("R9", 16'hA, 27'h10, 12'h008, 1'b1, 44'h2, 4'b0111);
        for (int i = 0; i < 7; i++) fill(16'hA, 27'(32 + i), 44'(100 + i), 4'b0001);
        probe("R9", 16'hA, 27'h10, 12'h008, 1'b1, 44'h2, 4'b0111);
        for (int i = 0; i < 7; i++)
            probe("R10", 16'hA, 27'(32 + i), 12'h123, 1'b1, 44'(100 + i), 4'b0001);
    endtask

    task automatic t_round_robin;
        // Full: slot0 = 0x10, slots1..7 = 32..38; pointer still at 0.
        fill(16'hA, 27'h50, 44'hCAFE, 4'b0101);
        probe("R10", 16'hA, 27'h10, 12'h0, 1'b0, '0, '0);
        probe("R10", 16'hA, 27'd32, 12'h0, 1'b1, 44'd100, 4'b0001);
        probe("R10", 16'hA, 27'h50, 12'h008, 1'b1, 44'hCAFE, 4'b0101);
        fill(16'hA, 27'h51, 44'hBEEF, 4'b0001);
        probe("R10", 16'hA, 27'd32, 12'h0, 1'b0, '0, '0);
        probe("R10", 16'hA, 27'd33, 12'h0, 1'b1, 44'd101, 4'b0001);
        probe("R10", 16'hA, 27'h50, 12'h0, 1'b1, 44'hCAFE, 4'b0101);
    endtask

    task automatic t_flush_asid;
        flush(1'b0, '0);
        fill(16'h5, 27'h40, 44'h11, 4'b0001);
        fill(16'h6, 27'h41, 44'h22, 4'b0011);
        fill(16'h5, 27'h42, 44'h33, 4'b0001);
        flush(1'b1, 16'h5);
        probe("R7", 16'h5, 27'h40, 12'h0, 1'b0, '0, '0);
        probe("R7", 16'h5, 27'h42, 12'h0, 1'b0, '0, '0);
        probe("R7", 16'h6, 27'h41, 12'h0, 1'b1, 44'h22, 4'b0011);
    endtask

    task automatic t_flush_all;
        fill(16'h7, 27'h60, 44'h44, 4'b1111);
        flush(1'b0, 16'h7);
        probe("R6", 16'h6, 27'h41, 12'h0, 1'b0, '0, '0);
        probe("R6", 16'h7, 27'h60, 12'h0, 1'b0, '0, '0);
    endtask

    task automatic t_flush_vs_fill;
        @(negedge clk);
        flush_en = 1'b1; flush_by_asid = 1'b0;
        fill_en = 1'b1; fill_asid = 16'h8; fill_vpn = 27'h70; fill_ppn = 44'h55; fill_perm = 4'b0001;
        @(negedge clk);
        flush_en = 1'b0; fill_en = 1'b0;
        probe("R8", 16'h8, 27'h70, 12'h0, 1'b0, '0, '0);
        @(negedge clk);
        flush_en = 1'b1; flush_by_asid = 1'b1; flush_asid = 16'h3;
        fill_en = 1'b1; fill_asid = 16'h8; fill_vpn = 27'h71; fill_ppn = 44'h56; fill_perm = 4'b0001;
        @(negedge clk);
        flush_en = 1'b0; fill_en = 1'b0;
        probe("R8", 16'h8, 27'h71, 12'h0, 1'b0, '0, '0);
    endtask

    task automatic report;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill_timing();
        t_asid();
        t_overwrite();
        t_round_robin();
        t_flush_asid();
        t_flush_all();
        t_flush_vs_fill();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

endmodule